// File: doc/BRIEF.md
# Return-Time Supervisor Guard Clearing

This block decides, for each retiring trap-return instruction, which supervisor guard bits must be dropped. A guard bit, once set by trap entry, marks that a supervisor-level handler is still inside its critical window. A further trap taken while the guard is set is treated as a double trap. Returning out of that window must release the guard, but only for the status words whose owner is actually being left.

The core presents the kind of return, its current privilege and virtualization, and the privilege and virtualization it is returning to. The target pair comes from the saved previous-mode fields, or from the debug control register for a debug return. One cycle later the block raises single-cycle clear strobes toward three places: the guard bit in the machine-level status word, the guard bit in the virtual-supervisor status register, and the modify-privilege bit.

Privilege codes on all privilege ports: user = 2'b00, supervisor = 2'b01, machine = 2'b11. Return kind codes: 2'b00 = no return, 2'b01 = machine return, 2'b10 = supervisor return, 2'b11 = debug return.

Top module: `ret_guard_clear`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, all three clear strobes are 0.
- R2: A machine return (kind 2'b01) whose target privilege is user (2'b00), or whose target is virtualized at any privilege, raises the machine guard clear strobe. A machine return to non-virtualized supervisor or to machine raises no strobe.
- R3: A machine return whose target is user privilege with virtualization set also raises the virtual-supervisor guard clear strobe. No other machine-return target raises it.
- R4: A debug return (kind 2'b11) applies the rules of R2 and R3 to its target privilege and virtualization.
- R5: A debug return whose target privilege is below machine (anything other than 2'b11) raises the modify-privilege clear strobe. Machine and supervisor returns never raise it.
- R6: A supervisor return (kind 2'b10) executed from non-virtualized supervisor privilege raises the machine guard clear strobe.
- R7: A supervisor return executed from supervisor privilege with virtualization set raises the virtual-supervisor guard clear strobe and not the machine guard clear strobe.
- R8: A supervisor return from non-virtualized supervisor privilege whose target is user privilege with virtualization set raises both guard clear strobes.
- R9: A supervisor return executed from user or machine privilege raises no strobe.
- R10: Each strobe rises in the cycle after the return is presented with ret_valid high, and lasts exactly one cycle. With ret_valid low, or with kind 2'b00, no strobe rises whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ret_valid | input | 1 | A return instruction retires this cycle |
| ret_kind | input | 2 | Return kind: 01 machine, 10 supervisor, 11 debug, 00 none |
| cur_priv | input | 2 | Privilege in which the return executes |
| cur_virt | input | 1 | Virtualization in which the return executes |
| tgt_priv | input | 2 | Privilege being returned to |
| tgt_virt | input | 1 | Virtualization being returned to |
| clr_mstat_guard | output | 1 | Pulse: clear the guard in the machine-level status word |
| clr_vs_guard | output | 1 | Pulse: clear the guard in the virtual-supervisor status register |
| clr_mod_priv | output | 1 | Pulse: clear the modify-privilege bit |

## Verification
Every cycle, the assertions check that no strobe appears without a valid return one cycle earlier, and that an idle cycle produces no strobe the next cycle. They also check that the modify-privilege strobe follows only debug returns, and that supervisor returns from user or machine stay silent. The directed scenarios cover the full selective mapping from target and source modes to individual strobes. This includes the negative cases, such as a machine return to plain supervisor and a virtualized supervisor return that must leave the machine guard alone, and a stream of back-to-back returns.

// File: rtl/rgc_pkg.sv
package rgc_pkg;
  localparam int PRIV_W = 2;
  localparam logic [PRIV_W-1:0] PRIV_USER = 2'b00;
  localparam logic [PRIV_W-1:0] PRIV_SUPV = 2'b01;
  localparam logic [PRIV_W-1:0] PRIV_MACH = 2'b11;

  typedef enum logic [1:0] {
    RK_NONE = 2'b00,
    RK_MRET = 2'b01,
    RK_SRET = 2'b10,
    RK_DRET = 2'b11
  } ret_kind_e;

  typedef struct packed {
    logic mstat;
    logic vs;
    logic mprv;
  } clr_set_t;

  localparam int CLR_W = $bits(clr_set_t);

  // Leaving toward user mode or into any guest mode drops the machine-level guard.
  function automatic logic leaves_host_supv(input logic [PRIV_W-1:0] p, input logic v);
    return (p == PRIV_USER) || v;
  endfunction

  // Landing in virtual user drops the guest supervisor guard.
  function automatic logic lands_guest_user(input logic [PRIV_W-1:0] p, input logic v);
    return (p == PRIV_USER) && v;
  endfunction
endpackage

// File: rtl/rgc_decode.sv
module rgc_decode
  import rgc_pkg::*;
(
  input  logic              fire,
  input  ret_kind_e         kind,
  input  logic [PRIV_W-1:0] cur_priv,
  input  logic              cur_virt,
  input  logic [PRIV_W-1:0] tgt_priv,
  input  logic              tgt_virt,
  output clr_set_t          clr
);
  logic from_supv;
  assign from_supv = (cur_priv == PRIV_SUPV);

  always_comb begin
    clr = '0;
    if (fire) begin
      unique case (kind)
        RK_MRET, RK_DRET: begin
          clr.mstat = leaves_host_supv(tgt_priv, tgt_virt);
          clr.vs    = lands_guest_user(tgt_priv, tgt_virt);
          clr.mprv  = (kind == RK_DRET) && (tgt_priv != PRIV_MACH);
        end
        RK_SRET: begin
          // the supervisor view written is the guest one when virtualized
          clr.mstat = from_supv && !cur_virt;
          clr.vs    = from_supv && (cur_virt ||
                      lands_guest_user(tgt_priv, tgt_virt));
        end
        default: clr = '0;
      endcase
    end
  end
endmodule

// File: rtl/rgc_pulse.sv
module rgc_pulse #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/ret_guard_clear.sv
module ret_guard_clear
  import rgc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ret_valid,
  input  logic [1:0] ret_kind,
  input  logic [1:0] cur_priv,
  input  logic       cur_virt,
  input  logic [1:0] tgt_priv,
  input  logic       tgt_virt,
  output logic       clr_mstat_guard,
  output logic       clr_vs_guard,
  output logic       clr_mod_priv
);
  ret_kind_e kind_dec;
  logic      retire_fire;
  clr_set_t  dec_set;
  clr_set_t  held_set;

  assign kind_dec    = ret_kind_e'(ret_kind);
  assign retire_fire = ret_valid && (kind_dec != RK_NONE);

  rgc_decode u_decode (
    .fire     (retire_fire),
    .kind     (kind_dec),
    .cur_priv (cur_priv),
    .cur_virt (cur_virt),
    .tgt_priv (tgt_priv),
    .tgt_virt (tgt_virt),
    .clr      (dec_set)
  );

  rgc_pulse #(.W(CLR_W)) u_pulse (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (dec_set),
    .q     (held_set)
  );

  assign clr_mstat_guard = held_set.mstat;
  assign clr_vs_guard    = held_set.vs;
  assign clr_mod_priv    = held_set.mprv;
endmodule

// File: rtl/ret_guard_clear_chk.sv
module ret_guard_clear_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ret_valid,
  input logic [1:0] ret_kind,
  input logic [1:0] cur_priv,
  input logic       retire_fire,
  input logic       clr_mstat_guard,
  input logic       clr_vs_guard,
  input logic       clr_mod_priv
);
  logic any_clr;
  assign any_clr = clr_mstat_guard | clr_vs_guard | clr_mod_priv;

  AST_STROBE_AFTER_RET: assert property (@(posedge clk) disable iff (!rst_n)
    any_clr |-> $past(ret_valid)); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !retire_fire |=> !any_clr); // R10

  AST_MPRV_DEBUG_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    clr_mod_priv |-> $past(ret_kind) == 2'b11); // R5

  AST_SRET_OUTSIDE_SUPV: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && ret_kind == 2'b10 && cur_priv != 2'b01) |=> !any_clr); // R9

  AST_NONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_kind == 2'b00) |=> !any_clr); // R10
endmodule

bind ret_guard_clear ret_guard_clear_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .ret_valid       (ret_valid),
  .ret_kind        (ret_kind),
  .cur_priv        (cur_priv),
  .retire_fire     (retire_fire),
  .clr_mstat_guard (clr_mstat_guard),
  .clr_vs_guard    (clr_vs_guard),
  .clr_mod_priv    (clr_mod_priv)
);

// File: tb/ret_guard_clear_tb_top.sv
module ret_guard_clear_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 5000;
  localparam logic [1:0] U = 2'b00, S = 2'b01, M = 2'b11;
  localparam logic [1:0] K_NONE = 2'b00, K_M = 2'b01, K_S = 2'b10, K_D = 2'b11;

  logic clk = 0;
  logic rst_n = 0;
  logic ret_valid = 0;
  logic [1:0] ret_kind = K_NONE;
  logic [1:0] cur_priv = M;
  logic cur_virt = 0;
  logic [1:0] tgt_priv = U;
  logic tgt_virt = 0;
  logic clr_mstat_guard, clr_vs_guard, clr_mod_priv;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ret_guard_clear dut_i (
    .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .ret_kind(ret_kind),
    .cur_priv(cur_priv), .cur_virt(cur_virt), .tgt_priv(tgt_priv), .tgt_virt(tgt_virt),
    .clr_mstat_guard(clr_mstat_guard), .clr_vs_guard(clr_vs_guard), .clr_mod_priv(clr_mod_priv)
  );

  task automatic check3(input string req, input logic [2:0] exp);
    logic [2:0] act;
    act = {clr_mstat_guard, clr_vs_guard, clr_mod_priv};
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: strobes {mstat,vs,mprv} actual %b expected %b", req, act, exp);
    end
  endtask

  // Present a return at a falling edge; the strobe register loads at the
  // next rising edge, so the pulse is sampled at the falling edge after it,
  // and must be gone one cycle later.
  task automatic ret_once(input string req, input logic v, input logic [1:0] k,
                          input logic [1:0] cp, input logic cv,
                          input logic [1:0] tp, input logic tv,
                          input logic [2:0] exp);
    ret_valid = v; ret_kind = k; cur_priv = cp; cur_virt = cv;
    tgt_priv = tp; tgt_virt = tv;
    @(negedge clk);
    check3(req, exp);
    ret_valid = 0; ret_kind = K_NONE;
    @(negedge clk);
    check3({req, " pulse end (R10)"}, 3'b000);
  endtask

  task automatic t_reset;
    rst_n = 0;
    repeat (3) @(negedge clk);
    check3("R1 during reset", 3'b000);
    rst_n = 1;
    @(negedge clk);
    check3("R1 after release", 3'b000);
  endtask

  task automatic t_mret;
    ret_once("R2 mret to U",        1, K_M, M, 0, U, 0, 3'b100);
    ret_once("R2 mret to HS",       1, K_M, M, 0, S, 0, 3'b000);
    ret_once("R2 mret to M",        1, K_M, M, 0, M, 0, 3'b000);
    ret_once("R2 mret to VS",       1, K_M, M, 0, S, 1, 3'b100);
    ret_once("R3 mret to VU",       1, K_M, M, 0, U, 1, 3'b110);
  endtask

  task automatic t_dret;
    ret_once("R4 R5 dret to U",     1, K_D, M, 0, U, 0, 3'b101);
    ret_once("R4 R5 dret to VU",    1, K_D, M, 0, U, 1, 3'b111);
    ret_once("R4 R5 dret to VS",    1, K_D, M, 0, S, 1, 3'b101);
    ret_once("R5 dret to HS",       1, K_D, M, 0, S, 0, 3'b001);
    ret_once("R5 dret to M",        1, K_D, M, 0, M, 0, 3'b000);
  endtask

  task automatic t_sret;
    ret_once("R6 sret HS to U",     1, K_S, S, 0, U, 0, 3'b100);
    ret_once("R6 sret HS to HS",    1, K_S, S, 0, S, 0, 3'b100);
    ret_once("R7 sret VS to VU",    1, K_S, S, 1, U, 1, 3'b010);
    ret_once("R7 sret VS to VS",    1, K_S, S, 1, S, 1, 3'b010);
    ret_once("R8 sret HS to VU",    1, K_S, S, 0, U, 1, 3'b110);
    ret_once("R8 sret HS to VS",    1, K_S, S, 0, S, 1, 3'b100);
    ret_once("R9 sret from M",      1, K_S, M, 0, U, 1, 3'b000);
    ret_once("R9 sret from U",      1, K_S, U, 0, U, 0, 3'b000);
  endtask

  task automatic t_no_effect;
    ret_once("R10 invalid mret",    0, K_M, M, 0, U, 1, 3'b000);
    ret_once("R10 invalid dret",    0, K_D, M, 0, U, 0, 3'b000);
    ret_once("R10 kind none",       1, K_NONE, S, 0, U, 1, 3'b000);
  endtask

  task automatic t_back_to_back;
    ret_valid = 1; ret_kind = K_M; cur_priv = M; cur_virt = 0; tgt_priv = U; tgt_virt = 1;
    @(negedge clk);
    check3("R3 b2b first", 3'b110);
    ret_kind = K_D; tgt_priv = S; tgt_virt = 0;
    @(negedge clk);
    check3("R5 b2b second", 3'b001);
    ret_kind = K_S; cur_priv = S; cur_virt = 1;
    @(negedge clk);
    check3("R7 b2b third", 3'b010);
    ret_valid = 0; ret_kind = K_NONE;
    @(negedge clk);
    check3("R10 b2b drain", 3'b000);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_mret();
    t_dret();
    t_sret();
    t_no_effect();
    t_back_to_back();
    finish_run();
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: run did not end, actual timeout expected completion");
    finish_run();
  end
endmodule